// File: doc/BRIEF.md
# Graceful Transmit/Receive Stop Controller

This block brings a MAC's transmit and receive paths to a clean halt on request and lets them resume later. Each direction has its own stop and resume pulse. A stop request returns at once. The affected path stops admitting new data frames. Any frame already under way runs to its end-of-frame strobe, and then the path counts as stopped. Reaching the stopped state raises a sticky completion event for that direction. On the receive side this event tells software that the receive configuration may now be rewritten safely.

The transmit side arbitrates between two upstream request lines, one for data frames and one for pause-control frames. It issues a one-cycle grant that also marks the start of the frame. Pause frames are granted even while transmit is stopped, so flow control keeps working during a halt. The receive side qualifies each incoming start-of-frame strobe with an admit output. The completion events live in a small bank. Each event has a mask bit and a write-one-to-clear acknowledge, and the bank drives a registered interrupt line.

Top module: `gsc_stop_ctrl`

## Requirements
- R1: After a synchronous reset both paths run, no event is set, all mask bits are 0, irq is 0, and an idle transmit path grants a data request combinationally.
- R2: A stop request on an idle path sets that path's event bit (bit 0 = transmit, bit 1 = receive) and its stopped flag at the clock edge that samples the request.
- R3: A stop request on a busy path leaves the event bit and stopped flag clear until the end-of-frame strobe of the frame in progress; both are set at the edge that samples that strobe.
- R4: From the cycle a stop request is presented until resume, no data frame is started: tx_data_grant stays 0 and rx_frame_admit stays 0 for any start-of-frame strobe.
- R5: While transmit is stopped and idle, a pause request is granted. tx_stopped drops while that pause frame runs and returns at the edge that samples its tx_eof. No new transmit event is raised.
- R6: With both request lines high on an idle running transmit path, the pause request wins: tx_pause_grant is 1 and tx_data_grant is 0.
- R7: A resume pulse returns its path to running at the next edge, so data grants and admits are issued again. A resume presented together with a stop request wins, and no event is raised.
- R8: Event bits stay set, including across resume, until a write-one-to-clear acknowledge. An acknowledge bit of 0 leaves its event unchanged. An event set in the same cycle as its acknowledge stays set.
- R9: irq is registered: it equals the OR over all bits of event AND mask as they stood before the previous clock edge.
- R10: Event bits are readable on evt_status regardless of the mask; a masked-off event does not raise irq.
- R11: The transmit path carries one frame at a time: neither grant is issued while a granted frame has not yet seen tx_eof.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_stop_req | input | 1 | Pulse: request graceful transmit stop |
| tx_resume | input | 1 | Pulse: enable transmit, clearing its stop request |
| rx_stop_req | input | 1 | Pulse: request graceful receive stop |
| rx_resume | input | 1 | Pulse: enable receive, clearing its stop request |
| tx_data_req | input | 1 | Upstream wants to send a data frame |
| tx_pause_req | input | 1 | Upstream wants to send a pause-control frame |
| tx_eof | input | 1 | Strobe: current transmit frame ended |
| rx_sof | input | 1 | Strobe: receive frame start seen on the line |
| rx_eof | input | 1 | Strobe: current admitted receive frame ended |
| evt_mask_we | input | 1 | Write strobe for the mask bits |
| evt_mask_wdata | input | 2 | New mask value (bit 0 transmit, bit 1 receive) |
| evt_ack_we | input | 1 | Acknowledge strobe |
| evt_ack_wdata | input | 2 | Bits to clear (1 clears) |
| tx_data_grant | output | 1 | Data frame granted; marks its start |
| tx_pause_grant | output | 1 | Pause frame granted; marks its start |
| rx_frame_admit | output | 1 | Receive start-of-frame accepted |
| tx_stopped | output | 1 | Transmit stopped and idle |
| rx_stopped | output | 1 | Receive stopped and idle |
| evt_status | output | 2 | Sticky completion events |
| irq | output | 1 | Registered masked interrupt |

## Verification
On every cycle the assertions check the grant rules: no data grant while a stop is pending or held, never two grants at once, and no grant on a busy transmitter. They also check that completion only arises on an idle path or at end of frame, that an idle stop reaches the stopped state in one edge, that events persist without acknowledge, and that a quiet masked event vector keeps irq low. The bench scenarios show the timing and ordering that need whole sequences to see. These include the drain through a frame in progress, a pause frame passing through a halted transmitter without a new event, and resume winning over a simultaneous stop. They also cover an event set racing its own acknowledge and the one-cycle lag of irq behind the events.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

    localparam int NUM_DIR = 2;
    localparam int DIR_TX  = 0;
    localparam int DIR_RX  = 1;

    typedef enum logic [1:0] {
        PS_RUN   = 2'd0,
        PS_DRAIN = 2'd1,
        PS_HALT  = 2'd2
    } path_state_e;

    typedef struct packed {
        logic stop;
        logic resume;
        logic start;
        logic fin;
    } path_in_t;

    typedef struct packed {
        path_state_e state;
        logic        busy;
        logic        done;
        logic        halted;
    } path_out_t;

    function automatic path_state_e path_next(path_state_e cur, path_in_t in,
                                              logic busy);
        path_state_e nxt;
        nxt = cur;
        if (in.resume) begin
            nxt = PS_RUN;
        end else begin
            case (cur)
                PS_RUN:   if (in.stop)
                              nxt = ((busy && !in.fin) || in.start) ? PS_DRAIN : PS_HALT;
                PS_DRAIN: if (in.fin) nxt = PS_HALT;
                default:  nxt = PS_HALT;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/gsc_path_fsm.sv
module gsc_path_fsm
    import gsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  path_in_t  pin,
    output path_out_t pout
);
    path_state_e state_q, state_d;
    logic        busy_q,  busy_d;

    always_comb begin
        state_d = path_next(state_q, pin, busy_q);
        busy_d  = busy_q;
        if (pin.start)    busy_d = 1'b1;
        else if (pin.fin) busy_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_RUN;
            busy_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            busy_q  <= busy_d;
        end
    end

    assign pout.state  = state_q;
    assign pout.busy   = busy_q;
    assign pout.done   = (state_q != PS_HALT) && (state_d == PS_HALT);
    assign pout.halted = (state_q == PS_HALT) && !busy_q;

    // R3
    done_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        pout.done |-> (!busy_q || pin.fin));

    // R2
    idle_stop_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_RUN && pin.stop && !pin.resume && !busy_q && !pin.start)
        |=> (state_q == PS_HALT));

    // R7
    resume_runs_chk: assert property (@(posedge clk) disable iff (rst)
        pin.resume |=> (state_q == PS_RUN));

endmodule

// File: rtl/gsc_tx_gate.sv
module gsc_tx_gate
    import gsc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  path_state_e state,
    input  logic        busy,
    input  logic        stop_req,
    input  logic        data_req,
    input  logic        pause_req,
    output logic        data_grant,
    output logic        pause_grant
);
    logic idle_slot;

    assign idle_slot   = !busy;
    assign pause_grant = pause_req && idle_slot;
    assign data_grant  = data_req && idle_slot && !pause_req
                         && (state == PS_RUN) && !stop_req;

    // R4
    no_data_when_stopping_chk: assert property (@(posedge clk) disable iff (rst)
        data_grant |-> (state == PS_RUN && !stop_req));

    // R6
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        !(data_grant && pause_grant));

    // R11
    grant_needs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (data_grant || pause_grant) |=> !(data_grant || pause_grant) || !busy);

endmodule

// File: rtl/gsc_event_bank.sv
module gsc_event_bank #(
    parameter int N_EVT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_EVT-1:0] set_i,
    input  logic             mask_we,
    input  logic [N_EVT-1:0] mask_wdata,
    input  logic             ack_we,
    input  logic [N_EVT-1:0] ack_wdata,
    output logic [N_EVT-1:0] evt_o,
    output logic             irq_o
);
    logic [N_EVT-1:0] evt_q, evt_d, mask_q, clr;
    logic             irq_q;

    assign clr = ack_we ? ack_wdata : '0;

    generate
        for (genvar i = 0; i < N_EVT; i++) begin : g_bit
            assign evt_d[i] = set_i[i] || (evt_q[i] && !clr[i]);

            // R8
            evt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
                (evt_q[i] && !clr[i]) |=> evt_q[i]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q  <= '0;
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            evt_q  <= evt_d;
            if (mask_we) mask_q <= mask_wdata;
            irq_q  <= |(evt_q & mask_q);
        end
    end

    assign evt_o = evt_q;
    assign irq_o = irq_q;

    // R10
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((evt_q & mask_q) == '0) |=> !irq_q);

endmodule

// File: rtl/gsc_stop_ctrl.sv
module gsc_stop_ctrl
    import gsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_stop_req,
    input  logic       tx_resume,
    input  logic       rx_stop_req,
    input  logic       rx_resume,
    input  logic       tx_data_req,
    input  logic       tx_pause_req,
    input  logic       tx_eof,
    input  logic       rx_sof,
    input  logic       rx_eof,
    input  logic       evt_mask_we,
    input  logic [1:0] evt_mask_wdata,
    input  logic       evt_ack_we,
    input  logic [1:0] evt_ack_wdata,
    output logic       tx_data_grant,
    output logic       tx_pause_grant,
    output logic       rx_frame_admit,
    output logic       tx_stopped,
    output logic       rx_stopped,
    output logic [1:0] evt_status,
    output logic       irq
);
    path_in_t     pin  [NUM_DIR];
    path_out_t    pout [NUM_DIR];
    logic [NUM_DIR-1:0] done_vec;

    logic tx_start;
    assign tx_start = tx_data_grant || tx_pause_grant;

    assign rx_frame_admit = rx_sof && (pout[DIR_RX].state == PS_RUN)
                            && !rx_stop_req && !pout[DIR_RX].busy;

    assign pin[DIR_TX] = '{stop: tx_stop_req, resume: tx_resume,
                           start: tx_start, fin: tx_eof};
    assign pin[DIR_RX] = '{stop: rx_stop_req, resume: rx_resume,
                           start: rx_frame_admit, fin: rx_eof};

    generate
        for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
            gsc_path_fsm i_path (
                .clk  (clk),
                .rst  (rst),
                .pin  (pin[d]),
                .pout (pout[d])
            );
            assign done_vec[d] = pout[d].done;
        end
    endgenerate

    gsc_tx_gate i_gate (
        .clk         (clk),
        .rst         (rst),
        .state       (pout[DIR_TX].state),
        .busy        (pout[DIR_TX].busy),
        .stop_req    (tx_stop_req),
        .data_req    (tx_data_req),
        .pause_req   (tx_pause_req),
        .data_grant  (tx_data_grant),
        .pause_grant (tx_pause_grant)
    );

    gsc_event_bank #(.N_EVT(NUM_DIR)) i_events (
        .clk        (clk),
        .rst        (rst),
        .set_i      (done_vec),
        .mask_we    (evt_mask_we),
        .mask_wdata (evt_mask_wdata),
        .ack_we     (evt_ack_we),
        .ack_wdata  (evt_ack_wdata),
        .evt_o      (evt_status),
        .irq_o      (irq)
    );

    assign tx_stopped = pout[DIR_TX].halted;
    assign rx_stopped = pout[DIR_RX].halted;

    // R4
    rx_no_admit_stopping_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_stopped && !rx_resume) |=> !rx_frame_admit || !rx_stopped);

endmodule

// File: tb/test_gsc_stop_ctrl.sv
module test_gsc_stop_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_stop_req = 0, tx_resume = 0, rx_stop_req = 0, rx_resume = 0;
    logic       tx_data_req = 0, tx_pause_req = 0, tx_eof = 0;
    logic       rx_sof = 0, rx_eof = 0;
    logic       evt_mask_we = 0, evt_ack_we = 0;
    logic [1:0] evt_mask_wdata = 0, evt_ack_wdata = 0;
    logic       tx_data_grant, tx_pause_grant, rx_frame_admit;
    logic       tx_stopped, rx_stopped, irq;
    logic [1:0] evt_status;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    gsc_stop_ctrl i_gsc_stop_ctrl (
        .clk(clk), .rst(rst),
        .tx_stop_req(tx_stop_req), .tx_resume(tx_resume),
        .rx_stop_req(rx_stop_req), .rx_resume(rx_resume),
        .tx_data_req(tx_data_req), .tx_pause_req(tx_pause_req), .tx_eof(tx_eof),
        .rx_sof(rx_sof), .rx_eof(rx_eof),
        .evt_mask_we(evt_mask_we), .evt_mask_wdata(evt_mask_wdata),
        .evt_ack_we(evt_ack_we), .evt_ack_wdata(evt_ack_wdata),
        .tx_data_grant(tx_data_grant), .tx_pause_grant(tx_pause_grant),
        .rx_frame_admit(rx_frame_admit),
        .tx_stopped(tx_stopped), .rx_stopped(rx_stopped),
        .evt_status(evt_status), .irq(irq)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 evt", {6'd0, evt_status}, 8'd0);
        chk("R1 irq", {7'd0, irq}, 8'd0);
        chk("R1 stopped", {6'd0, tx_stopped, rx_stopped}, 8'd0);
        tx_data_req = 1; #1;
        chk("R1 grant", {7'd0, tx_data_grant}, 8'd1);
        tx_data_req = 0; #1;
    endtask

    task automatic t_priority();
        tx_data_req = 1; tx_pause_req = 1; #1;
        chk("R6 pause", {7'd0, tx_pause_grant}, 8'd1);
        chk("R6 data", {7'd0, tx_data_grant}, 8'd0);
        tx_data_req = 0; tx_pause_req = 0; #1;
    endtask

    task automatic t_tx_idle_stop();
        tx_data_req = 1; tx_stop_req = 1; #1;
        chk("R4 same cycle", {7'd0, tx_data_grant}, 8'd0);
        cyc();
        tx_stop_req = 0; #1;
        chk("R2 evt", {6'd0, evt_status}, 8'd1);
        chk("R2 stopped", {7'd0, tx_stopped}, 8'd1);
        chk("R4 held", {7'd0, tx_data_grant}, 8'd0);
        cyc();
        chk("R10 polled", {6'd0, evt_status}, 8'd1);
        chk("R10 no irq", {7'd0, irq}, 8'd0);
        tx_data_req = 0;
    endtask

    task automatic t_pause_stopped();
        evt_ack_we = 1; evt_ack_wdata = 2'b01;
        cyc();
        evt_ack_we = 0;
        chk("R8 ack", {6'd0, evt_status}, 8'd0);
        tx_pause_req = 1; #1;
        chk("R5 pause grant", {7'd0, tx_pause_grant}, 8'd1);
        cyc();
        tx_pause_req = 0;
        chk("R5 busy", {7'd0, tx_stopped}, 8'd0);
        tx_pause_req = 1; #1;
        chk("R11 no second", {7'd0, tx_pause_grant}, 8'd0);
        tx_pause_req = 0; tx_eof = 1;
        cyc();
        tx_eof = 0;
        chk("R5 restopped", {7'd0, tx_stopped}, 8'd1);
        chk("R5 no event", {6'd0, evt_status}, 8'd0);
    endtask

    task automatic t_resume();
        tx_resume = 1;
        cyc();
        tx_resume = 0;
        chk("R7 running", {7'd0, tx_stopped}, 8'd0);
        tx_data_req = 1; #1;
        chk("R7 grant", {7'd0, tx_data_grant}, 8'd1);
        tx_data_req = 0;
        tx_stop_req = 1; tx_resume = 1;
        cyc();
        tx_stop_req = 0; tx_resume = 0;
        chk("R7 race evt", {6'd0, evt_status}, 8'd0);
        chk("R7 race run", {7'd0, tx_stopped}, 8'd0);
    endtask

    task automatic t_tx_busy_stop();
        evt_mask_we = 1; evt_mask_wdata = 2'b01;
        tx_data_req = 1; #1;
        chk("R11 start", {7'd0, tx_data_grant}, 8'd1);
        cyc();
        evt_mask_we = 0; tx_data_req = 0;
        tx_stop_req = 1;
        cyc();
        tx_stop_req = 0;
        repeat (3) cyc();
        chk("R3 drain evt", {6'd0, evt_status}, 8'd0);
        chk("R3 drain flag", {7'd0, tx_stopped}, 8'd0);
        tx_data_req = 1; #1;
        chk("R4 drain", {7'd0, tx_data_grant}, 8'd0);
        tx_data_req = 0; tx_eof = 1;
        cyc();
        tx_eof = 0;
        chk("R3 done", {6'd0, evt_status}, 8'd1);
        chk("R9 lag", {7'd0, irq}, 8'd0);
        cyc();
        chk("R9 irq", {7'd0, irq}, 8'd1);
        evt_ack_we = 1; evt_ack_wdata = 2'b01;
        cyc();
        evt_ack_we = 0;
        chk("R8 cleared", {6'd0, evt_status}, 8'd0);
        chk("R9 still", {7'd0, irq}, 8'd1);
        cyc();
        chk("R9 drop", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_rx();
        rx_sof = 1; #1;
        chk("R4 rx admit run", {7'd0, rx_frame_admit}, 8'd1);
        cyc();
        rx_sof = 0; rx_stop_req = 1;
        cyc();
        rx_stop_req = 0;
        chk("R3 rx drain", {6'd0, evt_status}, 8'd0);
        rx_sof = 1; #1;
        chk("R4 rx blocked", {7'd0, rx_frame_admit}, 8'd0);
        cyc();
        rx_sof = 0; rx_eof = 1;
        cyc();
        rx_eof = 0;
        chk("R3 rx done", {6'd0, evt_status}, 8'd2);
        chk("R3 rx flag", {7'd0, rx_stopped}, 8'd1);
        cyc();
        chk("R10 rx masked", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_ack_race();
        rx_resume = 1;
        cyc();
        rx_resume = 0;
        chk("R7 rx run", {7'd0, rx_stopped}, 8'd0);
        chk("R8 across resume", {6'd0, evt_status}, 8'd2);
        rx_stop_req = 1; evt_ack_we = 1; evt_ack_wdata = 2'b10;
        cyc();
        rx_stop_req = 0;
        chk("R8 set wins", {6'd0, evt_status}, 8'd2);
        evt_ack_wdata = 2'b01;
        cyc();
        chk("R8 zero bit", {6'd0, evt_status}, 8'd2);
        evt_ack_wdata = 2'b10;
        cyc();
        evt_ack_we = 0;
        chk("R8 clear rx", {6'd0, evt_status}, 8'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        cyc();
        t_reset();
        t_priority();
        t_tx_idle_stop();
        t_pause_stopped();
        t_resume();
        t_tx_busy_stop();
        t_rx();
        t_ack_race();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule